// File: doc/BRIEF.md
# Shortened BCH Parity Encoder for Flash Data Chunks

This block produces the check bits that a flash write path stores next to each 1024-byte data chunk. Bytes enter one per clock on a valid/ready stream. A start strobe marks the first byte of a chunk and a last strobe marks the final byte. Every byte is folded into a parity register that divides the message by the generator polynomial of a binary BCH code. The update handles eight bits per clock.

Once the final byte has been taken, the remainder leaves the block as a burst of parity bytes, one per clock, each qualified by a valid strobe. The input stays stalled until the burst ends. The field is GF(2^14), built on the fixed primitive polynomial 0x4443. The correction strength `T` is a parameter that defaults to 24, which gives 336 parity bits, or 42 bytes.

The code is shortened. Only the 8192 data bits pass through the divider, and the unused leading message positions count as zeros, so they cost no cycles. The generator polynomial is worked out at elaboration time. It is the product of the distinct minimal polynomials of alpha^1, alpha^3, ..., alpha^(2T-1). A badly framed chunk is discarded, and an error pulse reports it.

Top module: `bch_parity_enc`

## Requirements
- R1: The field order M is the smallest integer for which 2^M is greater than the chunk size in bits (14 for 1024 bytes). The primitive polynomial is 0x4443, where bit i is the coefficient of x^i. The emitted parity is the remainder of message·x^P divided by the generator, with P = T·M. Every syndrome S_i, for odd i from 1 to 2T-1, of the codeword formed by the message followed by the parity is therefore zero.
- R2: Input bit order is reversed within each byte. Bit 0 of a data byte enters the divider first, bit 7 enters last, and the first byte of the chunk holds the highest-degree message coefficients.
- R3: The parity burst contains exactly P/8 bytes (42 at the defaults). It starts in the cycle after the clock edge that accepts the last data byte and runs on consecutive cycles. The first byte holds the highest-degree remainder coefficients. Within each parity byte, bit 0 holds the highest of its eight coefficients and bit 7 the lowest.
- R4: A chunk of all-zero bytes yields parity bytes that are all zero.
- R5: `in_ready` is low during every cycle in which `par_valid` is high, and high at all other times.
- R6: A chunk is framed correctly when `in_start` is set exactly on its first accepted byte and `in_last` is set exactly on its 1024th. On any violation, `err` pulses high for one cycle after the offending edge, the partial chunk is dropped, no parity is emitted, and the next byte must carry `in_start`.
- R7: After a parity burst or an error, the divider restarts from zero, so the parity of the next chunk does not depend on any earlier traffic.
- R8: After reset, `in_ready` is 1, `par_valid` is 0 and `err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Block can take a data byte |
| in_data | input | 8 | Data byte |
| in_start | input | 1 | First byte of a chunk |
| in_last | input | 1 | Final byte of a chunk |
| par_valid | output | 1 | Parity byte present |
| par_data | output | 8 | Parity byte |
| err | output | 1 | One-cycle pulse on a framing violation |

## Verification
The embedded assertions check the cycle-level protocol on every clock. They confirm that the input is stalled during the burst, that a burst opens only after an accepted last byte, and that the divider is clear during the burst and on an error pulse. Whether the parity values are right can only be shown by the bench's scenarios. For each chunk, the bench evaluates every odd syndrome of the received codeword in its own GF(2^14) arithmetic. That includes single-bit messages at the highest and lowest message degree, which expose any bit-order mistake. The bench also replays each kind of framing fault and then runs a clean chunk after it.

// File: rtl/bch_parity_enc.sv
module bch_parity_enc #(
  parameter int DATA_BYTES = 1024,
  parameter int T = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_start,
  input  logic       in_last,
  output logic       par_valid,
  output logic [7:0] par_data,
  output logic       err
);

  function automatic int field_order(int bits);
    int m;
    m = 1;
    while ((1 << m) <= bits) m++;
    return m;
  endfunction

  localparam int M  = field_order(DATA_BYTES * 8);
  localparam int P  = T * M;
  localparam int PB = (P + 7) / 8;
  localparam int PW = PB * 8;
  localparam int CW = $clog2(DATA_BYTES + 1);
  localparam int OW = $clog2(PB + 1);
  localparam logic [M:0] PRIM = (M + 1)'('h4443);

  function automatic logic [M-1:0] gf_mul(logic [M-1:0] a, logic [M-1:0] b);
    logic [M-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < M; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[M-1] ? ((sh << 1) ^ PRIM[M-1:0]) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic logic [M-1:0] gf_pow(int e);
    logic [M-1:0] r, base;
    r    = M'(1);
    base = M'(2);
    for (int i = 0; i < 31; i++) begin
      if (((e >> i) & 1) == 1) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [P:0] gen_poly();
    logic [P:0]   g, acc;
    logic [M-1:0] c [0:M];
    logic [M-1:0] root;
    int n, j, d;
    bit lead, done;
    n = (1 << M) - 1;
    g = (P + 1)'(1);
    for (int i = 1; i < 2 * T; i += 2) begin
      lead = 1'b1;
      j = i;
      for (int k = 0; k < M; k++) begin
        j = (j * 2) % n;
        if (j < i) lead = 1'b0;
      end
      if (lead) begin
        for (int k = 0; k <= M; k++) c[k] = '0;
        c[0] = M'(1);
        root = gf_pow(i);
        d = 0;
        j = i;
        done = 1'b0;
        for (int k = 0; k < M; k++) begin
          if (!done) begin
            for (int s = M; s > 0; s--)
              if (s <= d + 1) c[s] = c[s-1] ^ gf_mul(c[s], root);
            c[0] = gf_mul(c[0], root);
            d++;
            root = gf_mul(root, root);
            j = (j * 2) % n;
            if (j == i) done = 1'b1;
          end
        end
        acc = '0;
        for (int s = 0; s <= M; s++)
          if (s <= d && c[s][0]) acc = acc ^ (g << s);
        g = acc;
      end
    end
    return g;
  endfunction

  localparam logic [P:0] GEN = gen_poly();

  typedef enum logic [1:0] {IDLE, DATA, OUT} st_t;

  st_t           st;
  logic [P-1:0]  lfsr, nxt;
  logic [PW-1:0] obuf;
  logic [CW-1:0] cnt, nxt_cnt;
  logic [OW-1:0] ocnt;
  logic          acc_b, fin, bad, fb;

  assign in_ready  = (st != OUT);
  assign par_valid = (st == OUT);
  assign acc_b     = in_valid && in_ready;
  assign nxt_cnt   = (st == IDLE) ? CW'(1) : cnt + CW'(1);
  assign fin       = (nxt_cnt == CW'(DATA_BYTES));
  assign bad       = ((st == IDLE) != in_start) || (in_last != fin);

  always_comb begin
    nxt = lfsr;
    fb  = 1'b0;
    for (int b = 0; b < 8; b++) begin
      fb  = in_data[b] ^ nxt[P-1];
      nxt = {nxt[P-2:0], 1'b0} ^ (fb ? GEN[P-1:0] : '0);
    end
  end

  always_comb
    for (int b = 0; b < 8; b++) par_data[b] = obuf[PW-1-b];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      lfsr <= '0;
      obuf <= '0;
      cnt  <= '0;
      ocnt <= '0;
      err  <= 1'b0;
    end else begin
      err <= 1'b0;
      if (st == OUT) begin
        obuf <= obuf << 8;
        ocnt <= ocnt + OW'(1);
        if (ocnt == OW'(PB - 1)) st <= IDLE;
      end else if (acc_b) begin
        if (bad) begin
          err  <= 1'b1;
          st   <= IDLE;
          lfsr <= '0;
          cnt  <= '0;
        end else if (fin) begin
          obuf <= PW'(nxt) << (PW - P);
          lfsr <= '0;
          cnt  <= '0;
          ocnt <= '0;
          st   <= OUT;
        end else begin
          lfsr <= nxt;
          cnt  <= nxt_cnt;
          st   <= DATA;
        end
      end
    end
  end

  // R5
  ready_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |-> !in_ready);

  // R3
  burst_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_valid) |-> $past(in_valid && in_ready && in_last));

  // R7
  burst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |-> (lfsr == '0));

  // R6
  err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!par_valid && lfsr == '0 && cnt == '0));

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

endmodule

// File: tb/sim_bch_parity_enc.sv
module sim_bch_parity_enc;
  localparam int NB = 1024;
  localparam int T  = 24;
  localparam int M  = 14;
  localparam int P  = T * M;
  localparam int PB = P / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, par_valid, err;
  logic [7:0] par_data;

  always #4 clk = ~clk;

  bch_parity_enc #(.DATA_BYTES(NB), .T(T)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_start(in_start), .in_last(in_last),
    .par_valid(par_valid), .par_data(par_data), .err(err));

  int vec = 0, bad = 0, pcount = 0, ecount = 0;
  logic [7:0] msg [0:NB-1];
  logic [7:0] par [0:63];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (par_valid) begin
      if (pcount < 64) par[pcount] = par_data;
      pcount++;
      chk(!in_ready, "R5", "in_ready during burst", longint'(in_ready), 0);
    end
    if (err) ecount++;
  end

  function automatic logic [M-1:0] gmul(logic [M-1:0] a, logic [M-1:0] b);
    logic [M-1:0] r = '0, s = a;
    for (int i = 0; i < M; i++) begin
      if (b[i]) r ^= s;
      s = s[M-1] ? ((s << 1) ^ 14'h0443) : (s << 1);
    end
    return r;
  endfunction

  task automatic put(logic [7:0] d, logic s, logic l);
    in_data = d; in_start = s; in_last = l; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_chunk(int kind, string req);
    logic [31:0] lcg = 32'h1234_5678;
    bit nz = 0;
    for (int i = 0; i < NB; i++) begin
      case (kind)
        0: msg[i] = 8'h00;
        1: msg[i] = 8'hFF;
        2: msg[i] = 8'(i * 37 + 5);
        3: msg[i] = (i == 0) ? 8'h01 : 8'h00;
        4: msg[i] = (i == NB - 1) ? 8'h80 : 8'h00;
        default: begin lcg = lcg * 32'd1664525 + 32'd1013904223; msg[i] = lcg[31:24]; end
      endcase
    end
    pcount = 0; ecount = 0;
    for (int i = 0; i < NB; i++) put(msg[i], i == 0, i == NB - 1);
    chk(par_valid, "R3", "par_valid right after last", longint'(par_valid), 1);
    settle(PB + 4);
    chk(pcount == PB, "R3", "parity byte count", pcount, PB);
    chk(ecount == 0, "R6", "err on clean chunk", ecount, 0);
    for (int i = 0; i < PB; i++) if (par[i] != 0) nz = 1;
    if (kind == 0) chk(!nz, "R4", "zero chunk parity nonzero", longint'(nz), 0);
    else chk(nz, req, "parity all zero for nonzero data", longint'(nz), 1);
    for (int i = 1; i < 2 * T; i += 2) begin
      logic [M-1:0] a = 14'd1, s = '0;
      for (int k = 0; k < i; k++) a = gmul(a, 14'd2);
      for (int b = 0; b < NB; b++)
        for (int q = 0; q < 8; q++) s = gmul(s, a) ^ M'(msg[b][q]);
      for (int b = 0; b < PB; b++)
        for (int q = 0; q < 8; q++) s = gmul(s, a) ^ M'(par[b][q]);
      chk(s == 0, req, $sformatf("syndrome S%0d kind %0d", i, kind), longint'(s), 0);
    end
  endtask

  task automatic expect_err(string what);
    settle(3);
    chk(ecount == 1, "R6", {what, " err pulses"}, ecount, 1);
    chk(pcount == 0, "R6", {what, " parity emitted"}, pcount, 0);
    chk(in_ready, "R6", {what, " in_ready"}, longint'(in_ready), 1);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    #2;
    chk(in_ready, "R8", "in_ready after reset", longint'(in_ready), 1);
    chk(!par_valid, "R8", "par_valid after reset", longint'(par_valid), 0);
    chk(!err, "R8", "err after reset", longint'(err), 0);
    settle(1);

    run_chunk(0, "R4");
    run_chunk(1, "R1");
    run_chunk(2, "R1");
    run_chunk(3, "R2");
    run_chunk(4, "R2");

    pcount = 0; ecount = 0;
    put(8'h11, 1'b0, 1'b0);
    expect_err("no start");

    pcount = 0; ecount = 0;
    put(8'h22, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) put(8'h33, 1'b0, 1'b0);
    put(8'h44, 1'b0, 1'b1);
    expect_err("early last");

    pcount = 0; ecount = 0;
    for (int i = 0; i < NB; i++) put(8'(i), i == 0, 1'b0);
    expect_err("missing last");

    pcount = 0; ecount = 0;
    put(8'h55, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) put(8'h66, 1'b0, 1'b0);
    put(8'h77, 1'b1, 1'b0);
    expect_err("second start");

    run_chunk(5, "R7");
    run_chunk(0, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule